// File: doc/BRIEF.md
# Parallel Eight-Lane LFSR Keystream Generator

This block produces a keystream one byte at a time from eight 20-bit linear feedback shift registers running side by side. Each register, called a lane here, has its own feedback tap mask that is set at run time. Every lane contributes one bit to each output byte, so the lanes together act as a bit-sliced byte generator.

A single-cycle load pulse captures a 160-bit initialisation vector and eight tap masks. Each accepted step request then advances all lanes by one position. One cycle later the block presents a registered output byte with a one-cycle valid strobe. Mixing the keystream into data is left to the surrounding logic.

Top module: `lfsr_byte_ks`

## Requirements
- R1: A synchronous active-high reset clears every lane register and every stored tap mask. It also drives `ks_byte` to 0x00 and `ks_valid` low. A step after reset with no load therefore yields 0x00.
- R2: When `load` is high at a clock edge, lane k takes its initial contents from `iv[159-20*k -: 20]`, so lane 0 is loaded from the top 20 bits. Lane k takes its tap mask from `taps[159-20*k -: 20]`.
- R3: On each advance, a lane's new bit 0 is the XOR reduction of its register ANDed with that lane's stored tap mask.
- R4: On each advance, a lane's output bit is its bit 19 before the shift, and the register shifts left by one.
- R5: In the output byte, bit k is lane k's output bit, so lane 7 is the MSB and lane 0 is the LSB.
- R6: A step request at a clock edge with `load` low advances all eight lanes once. The resulting byte appears on `ks_byte` with `ks_valid` high during the following cycle. `ks_valid` is high for exactly one cycle per accepted request, and step held high yields a byte every cycle.
- R7: A step request in the same cycle as `load` is ignored. `ks_valid` stays low, and the first byte after the load comes from the freshly loaded contents.
- R8: A tap mask of zero is legal. That lane then inserts a 0 on every advance, so after 20 advances its output bit stays 0.
- R9: While `step` is low, the lanes keep their state and `ks_valid` stays low.
- R10: Tap masks are sampled only at load. Later changes on the `taps` input do not affect the keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture IV and tap masks |
| iv | input | 160 | Initial lane contents, lane 0 in the top field |
| taps | input | 160 | Per-lane tap masks, lane 0 in the top field |
| step | input | 1 | Request one keystream byte |
| ks_byte | output | 8 | Registered keystream byte, lane 7 in the MSB |
| ks_valid | output | 1 | One-cycle strobe marking a new byte |

## Verification
The hardest situation to reach from the ports is the lane state that hides behind the output, since only bit 19 of each lane is ever visible. This covers a step that was swallowed by a simultaneous load, a stored tap mask that differs from the current input, and a zero mask that slowly drains a lane.

The stimulus makes these visible through long runs of consecutive steps. The byte stream is compared with a reference model at every position, so any extra shift, wrong mask or dropped feedback shows up within twenty bytes. The run deliberately changes `taps` after loading, mixes idle gaps into the stream, and reloads while a step is pending.

// File: rtl/lfsr_ks_pkg.sv
package lfsr_ks_pkg;
  localparam int unsigned KS_LANES  = 8;
  localparam int unsigned KS_LANE_W = 20;

  function automatic logic fold_xor(input logic [KS_LANE_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/ks_lane.sv
module ks_lane #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] tap,
  output logic         msb
);
  logic [W-1:0] state_q;
  logic [W-1:0] tap_q;
  logic         fb;

  assign fb  = ^(state_q & tap_q);
  assign msb = state_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      tap_q   <= '0;
    end else if (load) begin
      state_q <= seed;
      tap_q   <= tap;
    end else if (adv) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end

  // R2
  seed_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (state_q == $past(seed)) && (tap_q == $past(tap)));

  // R4
  shift_left_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> state_q[W-1:1] == $past(state_q[W-2:0]));

  // R8
  zero_tap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && tap_q == '0) |=> state_q[0] == 1'b0);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(state_q) && $stable(tap_q));
endmodule

// File: rtl/lfsr_byte_ks.sv
module lfsr_byte_ks
  import lfsr_ks_pkg::*;
#(
  parameter int unsigned LANES  = KS_LANES,
  parameter int unsigned LANE_W = KS_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [LANES*LANE_W-1:0] iv,
  input  logic [LANES*LANE_W-1:0] taps,
  input  logic                    step,
  output logic [LANES-1:0]        ks_byte,
  output logic                    ks_valid
);
  localparam int unsigned VEC_W = LANES * LANE_W;

  logic             adv;
  logic [LANES-1:0] lane_bits;
  logic [LANES-1:0] byte_q;
  logic             valid_q;

  assign adv = step & ~load;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ks_lane #(.W(LANE_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .adv  (adv),
      .seed (iv[VEC_W-1-k*LANE_W -: LANE_W]),
      .tap  (taps[VEC_W-1-k*LANE_W -: LANE_W]),
      .msb  (lane_bits[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= adv;
      if (adv) byte_q <= lane_bits;
    end
  end

  assign ks_byte  = byte_q;
  assign ks_valid = valid_q;

  // R6
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    ks_valid |-> $past(step) && !$past(load));

  // R7
  load_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !ks_valid);

  // R9
  idle_novalid_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> !ks_valid);
endmodule

// File: tb/lfsr_byte_ks_tb.sv
module lfsr_byte_ks_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst, load, step;
  logic [159:0] iv, taps;
  logic [7:0]   ks_byte;
  logic         ks_valid;

  int checks = 0;
  int fails  = 0;

  logic [19:0] m_reg [8];
  logic [19:0] m_tap [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_byte_ks u_dut (
    .clk(clk), .rst(rst), .load(load), .iv(iv), .taps(taps),
    .step(step), .ks_byte(ks_byte), .ks_valid(ks_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_byte();
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = m_reg[k][19];
    return b;
  endfunction

  function automatic void m_adv();
    for (int k = 0; k < 8; k++)
      m_reg[k] = {m_reg[k][18:0], ^(m_reg[k] & m_tap[k])};
  endfunction

  // Drive load for one cycle; step may be asserted alongside it.
  task automatic do_load(input logic [159:0] v, input logic [159:0] t, input logic with_step);
    @(negedge clk);
    iv = v; taps = t; load = 1'b1; step = with_step;
    for (int k = 0; k < 8; k++) begin
      m_reg[k] = v[159-20*k -: 20];
      m_tap[k] = t[159-20*k -: 20];
    end
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    check(with_step ? "R7" : "R2", {31'd0, ks_valid}, 32'd0);
  endtask

  // n consecutive steps with step held high; each byte checked.
  task automatic run_steps(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step = 1'b1;
      @(negedge clk);
      check(req, {31'd0, ks_valid}, 32'd1);
      check(req, {24'd0, ks_byte}, {24'd0, m_byte()});
      m_adv();
    end
    step = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1", {31'd0, ks_valid}, 32'd0);
    check("R1", {24'd0, ks_byte}, 32'd0);
    for (int k = 0; k < 8; k++) begin m_reg[k] = '0; m_tap[k] = '0; end
    run_steps(3, "R1");
  endtask

  task automatic t_basic();
    // lane order and mapping visible in the first byte: lanes 0,2,4,6 MSB=1
    do_load({20'h80000, 20'h00001, 20'h80000, 20'h00001,
             20'h80000, 20'h00001, 20'h80000, 20'h00001},
            {8{20'h80009}}, 1'b0);
    check("R5", {24'd0, u_dut.ks_byte}, {24'd0, ks_byte});
    run_steps(1, "R5");
    run_steps(60, "R3");
  endtask

  task automatic t_mixed();
    do_load(160'h3c5a9_f0123_abcde_11111_7e7e7_00f0f_ca5e5_98765,
            160'h90000_a0001_c8005_80009_e0000_b4000_8c001_a2002, 1'b0);
    run_steps(40, "R4");
  endtask

  task automatic t_idle();
    run_steps(5, "R6");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9", {31'd0, ks_valid}, 32'd0);
    end
    run_steps(25, "R9");
  endtask

  task automatic t_tap_change();
    do_load(160'h12345_6789a_bcdef_fedcb_a9876_54321_0f0f0_f0f0f,
            160'h90000_90000_a0001_a0001_c8005_c8005_80009_80009, 1'b0);
    taps = 160'h0;
    run_steps(40, "R10");
  endtask

  task automatic t_zero_tap();
    do_load({8{20'hfffff}},
            {20'h0, 20'h90000, 20'h0, 20'h80009, 20'h0, 20'h0, 20'ha0001, 20'h0},
            1'b0);
    run_steps(30, "R8");
    check("R8", {31'd0, ks_byte[0] | ks_byte[2] | ks_byte[4] | ks_byte[5] | ks_byte[7]}, 32'd0);
  endtask

  task automatic t_step_in_load();
    run_steps(3, "R6");
    step = 1'b1;
    do_load(160'hfedcb_a9876_54321_0fedc_ba987_65432_10fed_cba98,
            160'h90000_a0001_c8005_80009_e0000_b4000_8c001_a2002, 1'b1);
    run_steps(22, "R7");
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; step = 1'b0; iv = '0; taps = '0;
    t_reset();
    t_basic();
    t_mixed();
    t_idle();
    t_tap_change();
    t_zero_tap();
    t_step_in_load();
    @(negedge clk);
    check("R6", {31'd0, ks_valid}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule